// File: doc/BRIEF.md
# Parallel I/O Port with Edge and Level Interrupts

This block is a small parallel I/O port of up to 32 pins on a simple register bus. Software reaches four registers at word-aligned byte addresses. It can drive any pin as an output, read back pin levels, and get an interrupt when pins change or are held high. The block does not contain pad cells. For each pin it drives an output-enable and an output value, and it samples the raw pin level through a two-flop synchroniser.

The interrupt trigger is chosen when the block is elaborated and cannot be changed at run time. The four choices are rising edge, falling edge, both edges, or level-high. In the three edge modes, detected edges are held in a sticky capture register. Software clears a captured bit by writing a one to it. In level-high mode no event is stored. The interrupt line follows the masked pin data directly.

The bus read port is combinational on the address. A write commits on the clock edge where the write enable is high.

Top module: `pio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: the output latch, direction, mask and capture registers, every `pin_oe` bit and `irq`.
- R2: Address bits [3:2] select the register. 0 is data, 1 is direction, 2 is interrupt mask and 3 is edge capture. Direction and mask read back the value last written.
- R3: Register bits at or above `NUM_PINS` read as zero, and writes to them are ignored.
- R4: A direction bit of 1 makes the pin an output. `pin_oe` equals the direction register, and `pin_out` equals the last value written to the data register. A data read returns the output latch for output pins and the synchronised level for input pins.
- R5: A pin level change is not yet visible in a data read after one rising clock edge. It is visible after the second.
- R6: In rising mode, a 0-to-1 change of a synchronised pin sets its capture bit.
- R7: In falling mode, a 1-to-0 change sets its capture bit.
- R8: In both-edges mode, either change sets its capture bit.
- R9: Writing 1 to a capture bit clears it. Writing 0 to a capture bit leaves it unchanged.
- R10: If an edge is detected in the same cycle as a write-one-to-clear of that bit, the bit stays set.
- R11: In edge modes, `irq` is high exactly when some pin has both its capture bit and its mask bit set. It stays high until every such bit is cleared or masked.
- R12: In level-high mode, `irq` is high exactly when some pin has both its data read bit and its mask bit high. The capture register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register; bits [3:2] decode |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data, zero-extended |
| pin_in | input | NUM_PINS | Raw asynchronous pin levels |
| pin_out | output | NUM_PINS | Output values for the pads |
| pin_oe | output | NUM_PINS | Output enables for the pads |
| irq | output | 1 | Interrupt to the host |

## Verification
The hardest case to reach is an edge and a clear write to the same capture bit in the same clock cycle. The edge only shows up two synchroniser stages after the pin moves. The bench therefore changes a pin on a falling clock edge and counts two rising edges. It then places the clear write so that it commits on the very edge where the detector fires, and confirms that the bit survives. Four instances with a shared bus and shared pins, one per trigger mode, are driven through a sweep of pin patterns and of all 64 masks.

// File: rtl/gpio_irq_pkg.sv
// Package: shared types for the parallel I/O port.
// Assumes a 32-bit data bus and byte addresses with word-aligned registers.
package gpio_irq_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_CAP  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop synchroniser for a vector of independent asynchronous pins.
// Assumes each bit is unrelated to the others (no bus-coherent crossing).
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Purpose: shift raw levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_regfile.sv
// Module: output latch, direction and interrupt-mask registers.
// Assumes the caller has already decoded the register select and cut
// the write data to the pin width.
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] mask_q
);
    // Purpose: load the selected control register on a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_DATA: out_q  <= wr_data;
                SEL_DIR:  dir_q  <= wr_data;
                SEL_MASK: mask_q <= wr_data;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_edge_cap.sv
// Module: per-pin edge detector and sticky capture register with
// write-one-to-clear. The trigger mode picks the detector at elaboration.
// In level mode no events are generated and the capture stays zero.
// Assumes lvl is already synchronous to clk.
module gpio_edge_cap
    import gpio_irq_pkg::*;
#(
    parameter int         WIDTH     = 8,
    parameter trig_mode_e TRIG_MODE = TRIG_RISE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] cap_q
);
    logic [WIDTH-1:0] evt;

    generate
        if (TRIG_MODE == TRIG_LEVEL) begin : g_level
            logic unused_lvl;
            assign unused_lvl = ^lvl;
            assign evt = '0;
        end else begin : g_edge
            logic [WIDTH-1:0] prev_q;

            // Purpose: remember last cycle's synchronised level.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= '0;
                else        prev_q <= lvl;
            end

            if (TRIG_MODE == TRIG_RISE) begin : g_rise
                assign evt = lvl & ~prev_q;
            end else if (TRIG_MODE == TRIG_FALL) begin : g_fall
                assign evt = ~lvl & prev_q;
            end else begin : g_both
                assign evt = lvl ^ prev_q;
            end
        end
    endgenerate

    // Purpose: clear written-one bits, then let new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~clr) | evt;
    end

    // R6
    cap_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap_q & ~$past(cap_q)) & ~$past(evt)) == '0);

    // R10
    edge_over_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((cap_q & $past(evt)) == $past(evt)));

    // R9
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~evt) != '0) |=> ((cap_q & $past(clr & ~evt)) == '0));
endmodule

// File: rtl/pio_irq_ctrl.sv
// Module: top of the parallel I/O port. It decodes the register bus,
// muxes read data, and forms the interrupt according to the trigger mode.
// Assumes 1 <= NUM_PINS <= 32. Reads are combinational; writes commit
// at the clock edge.
module pio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int         NUM_PINS  = 32,
    parameter trig_mode_e TRIG_MODE = TRIG_RISE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [NUM_PINS-1:0]  pin_in,
    output logic [NUM_PINS-1:0]  pin_out,
    output logic [NUM_PINS-1:0]  pin_oe,
    output logic                 irq
);
    localparam logic [BUS_W-1:0] PIN_MASK = BUS_W'({NUM_PINS{1'b1}});

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] wdata_w;
    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] out_q, dir_q, mask_q, cap_q;
    logic [NUM_PINS-1:0] clr_w;
    logic [NUM_PINS-1:0] data_view;
    logic [NUM_PINS-1:0] rd_w;
    logic                unused_bus;

    assign sel        = reg_sel_e'(bus_addr[3:2]);
    assign wdata_w    = bus_wdata[NUM_PINS-1:0];
    assign unused_bus = ^{bus_addr[1:0], bus_wdata};
    assign clr_w      = (bus_wr && sel == SEL_CAP) ? wdata_w : '0;

    gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_lvl)
    );

    gpio_regfile #(.WIDTH(NUM_PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_sel  (sel),
        .wr_data (wdata_w),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .mask_q  (mask_q)
    );

    gpio_edge_cap #(.WIDTH(NUM_PINS), .TRIG_MODE(TRIG_MODE)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sync_lvl),
        .clr   (clr_w),
        .cap_q (cap_q)
    );

    // Purpose: merge driven values and sampled levels per pin direction.
    assign data_view = (out_q & dir_q) | (sync_lvl & ~dir_q);

    // Purpose: select read data by address.
    always_comb begin
        case (sel)
            SEL_DATA: rd_w = data_view;
            SEL_DIR:  rd_w = dir_q;
            SEL_MASK: rd_w = mask_q;
            default:  rd_w = cap_q;
        endcase
    end

    assign bus_rdata = BUS_W'(rd_w);
    assign pin_out   = out_q;
    assign pin_oe    = dir_q;

    generate
        if (TRIG_MODE == TRIG_LEVEL) begin : g_irq_level
            assign irq = |(data_view & mask_q);
        end else begin : g_irq_edge
            assign irq = |(cap_q & mask_q);

            // R11
            irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (irq && !bus_wr) |=> irq);
        end
    endgenerate

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~PIN_MASK) == '0);
endmodule

// File: tb/test_pio_irq_ctrl.sv
`timescale 1ns/1ps
module test_pio_irq_ctrl;
    import gpio_irq_pkg::*;

    localparam int N = 6;
    localparam logic [31:0] ALL = 32'h3F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [N-1:0] pins = '0;

    logic [31:0]  rd [4];
    logic [N-1:0] po [4];
    logic [N-1:0] oe [4];
    logic         iq [4];

    int tests = 0;
    int fails = 0;
    logic [N-1:0] prev_p = '0;
    logic [N-1:0] exp_cap [3];
    logic [N-1:0] cur_mask = '0;

    always #4 clk = ~clk;

    pio_irq_ctrl #(.NUM_PINS(N), .TRIG_MODE(TRIG_RISE)) i_pio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rd[0]), .pin_in(pins),
        .pin_out(po[0]), .pin_oe(oe[0]), .irq(iq[0]));
    pio_irq_ctrl #(.NUM_PINS(N), .TRIG_MODE(TRIG_FALL)) i_pio_irq_ctrl_fall (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rd[1]), .pin_in(pins),
        .pin_out(po[1]), .pin_oe(oe[1]), .irq(iq[1]));
    pio_irq_ctrl #(.NUM_PINS(N), .TRIG_MODE(TRIG_BOTH)) i_pio_irq_ctrl_both (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rd[2]), .pin_in(pins),
        .pin_out(po[2]), .pin_oe(oe[2]), .irq(iq[2]));
    pio_irq_ctrl #(.NUM_PINS(N), .TRIG_MODE(TRIG_LEVEL)) i_pio_irq_ctrl_level (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rd[3]), .pin_in(pins),
        .pin_out(po[3]), .pin_oe(oe[3]), .irq(iq[3]));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 4'hC)
            for (int k = 0; k < 3; k++) exp_cap[k] &= ~d[N-1:0];
        if (a == 4'h8) cur_mask = d[N-1:0];
    endtask

    task automatic rd_chk(input string req, input int idx, input logic [3:0] a,
                          input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, rd[idx], exp);
    endtask

    task automatic set_pins(input logic [N-1:0] p);
        @(negedge clk);
        pins = p;
        repeat (4) @(posedge clk);
        exp_cap[0] |= p & ~prev_p;
        exp_cap[1] |= ~p & prev_p;
        exp_cap[2] |= p ^ prev_p;
        prev_p = p;
    endtask

    task automatic cap_chk;
        rd_chk("R6 rising capture", 0, 4'hC, 32'(exp_cap[0]));
        rd_chk("R7 falling capture", 1, 4'hC, 32'(exp_cap[1]));
        rd_chk("R8 both-edge capture", 2, 4'hC, 32'(exp_cap[2]));
    endtask

    task automatic irq_chk(input string req);
        #1;
        for (int k = 0; k < 3; k++)
            chk(req, 32'(iq[k]), 32'(|(exp_cap[k] & cur_mask)));
        chk("R12 level irq", 32'(iq[3]), 32'(|(prev_p & cur_mask)));
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) exp_cap[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int k = 0; k < 4; k++) begin
            rd_chk("R1 reset data", k, 4'h0, 32'h0);
            rd_chk("R1 reset dir", k, 4'h4, 32'h0);
            rd_chk("R1 reset mask", k, 4'h8, 32'h0);
            rd_chk("R1 reset cap", k, 4'hC, 32'h0);
            chk("R1 reset oe", 32'(oe[k]), 32'h0);
            chk("R1 reset out", 32'(po[k]), 32'h0);
            chk("R1 reset irq", 32'(iq[k]), 32'h0);
        end

        // R2, R3 register decode and unimplemented bits
        wr(4'h8, 32'hFFFF_FFFF);
        rd_chk("R3 mask upper bits", 0, 4'h8, ALL);
        wr(4'h8, 32'h0000_002A);
        rd_chk("R2 mask readback", 0, 4'h8, 32'h2A);
        wr(4'h8, 32'h0);
        wr(4'h4, 32'hFFFF_FF0F);
        rd_chk("R3 dir upper bits", 0, 4'h4, 32'h0F);
        chk("R4 pin_oe follows dir", 32'(oe[0]), 32'h0F);
        wr(4'h0, 32'hFFFF_FF35);
        chk("R4 pin_out follows latch", 32'(po[0]), 32'h35);
        set_pins(6'h2A);
        rd_chk("R4 mixed data read", 0, 4'h0, 32'h25);
        wr(4'h4, 32'h0);
        rd_chk("R4 all-input data read", 0, 4'h0, 32'h2A);
        rd_chk("R12 level cap reads zero", 3, 4'hC, 32'h0);

        // R5 synchroniser latency
        @(negedge clk);
        pins = prev_p ^ 6'h01;
        @(posedge clk);
        rd_chk("R5 not visible after one edge", 0, 4'h0, 32'(prev_p));
        @(posedge clk);
        rd_chk("R5 visible after two edges", 0, 4'h0, 32'(prev_p ^ 6'h01));
        repeat (2) @(posedge clk);
        exp_cap[0] |= pins & ~prev_p;
        exp_cap[1] |= ~pins & prev_p;
        exp_cap[2] |= pins ^ prev_p;
        prev_p = pins;
        cap_chk();

        // R6-R9 pattern sweep with periodic clears
        for (int i = 0; i < 64; i++) begin
            set_pins(6'((i * 13 + 7) & 63));
            cap_chk();
            if (i % 8 == 3) begin
                wr(4'hC, 32'h05);
                cap_chk();
            end
            if (i % 8 == 7) begin
                wr(4'hC, 32'hFFFF_FFFF);
                rd_chk("R9 clear all", 2, 4'hC, 32'h0);
                cap_chk();
            end
        end

        // R11, R12 mask sweep with live captures
        set_pins(6'h15);
        set_pins(6'h2A);
        for (int m = 0; m < 64; m++) begin
            wr(4'h8, 32'(m));
            irq_chk("R11 edge irq vs mask");
        end
        wr(4'h8, ALL);
        for (int b = 0; b < N; b++) begin
            wr(4'hC, 32'(1 << b));
            irq_chk("R11 irq held until last clear");
        end
        set_pins(6'h00);
        irq_chk("R12 level irq drops without clear");
        wr(4'hC, ALL);
        irq_chk("R11 irq after full clear");

        // R10 edge and clear in the same cycle
        wr(4'h8, 32'h0);
        wr(4'hC, ALL);
        @(negedge clk);
        pins = 6'h01;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_addr = 4'hC; bus_wr = 1'b1; bus_wdata = 32'h01;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk("R10 rising edge beats clear", rd[0], 32'h01);
        chk("R10 both-edge edge beats clear", rd[2], 32'h01);
        chk("R10 falling unaffected", rd[1], 32'h00);
        prev_p = 6'h01;
        exp_cap[0] = 6'h01; exp_cap[1] = '0; exp_cap[2] = 6'h01;
        wr(4'hC, 32'h01);
        cap_chk();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule